// File: doc/BRIEF.md
# Bufferless Router Output Port with Early Arbitration

This block is the output side of one port in a router that keeps no input buffers, no virtual channels and no credits. Every input offers the flit it currently holds with a valid signal plus head and tail markers. A round-robin arbiter private to this output picks one requester per cycle. The grant is the input's ready signal, so the flit leaves its input stage on that clock edge. The chosen flit passes through one pipeline register and then enters a three-slot output elastic buffer. That buffer drives the outgoing channel with a ready/valid pair.

Arbitration runs one cycle ahead of the buffer write and sees no credit return. For that reason a grant is issued only when the buffer plus the flit in the pipeline register leave room for one more flit. The count does not include a pop that may happen in the same cycle. Packets never interleave on the output. Once a head flit without a tail wins, the port is held for that input until the input's tail flit is granted. A packet of one flit carries both markers and does not hold the port.

Top module: `elastic_out_port`

## Requirements
- R1: While reset is asserted and right after it, `out_valid` is 0, and no `in_ready` is raised unless some `in_valid` is high.
- R2: At most one bit of `in_ready` is 1 in a cycle, and only for an input whose `in_valid` is 1. A flit is transferred on every cycle where both bits are 1.
- R3: While the port is not held, only an input presenting a head flit (`in_head`=1) can win. The winner is the first requester found from the priority pointer upward, wrapping from N_IN-1 to 0. The pointer starts at input 0 after reset. It moves to the input after the winner only when the granted flit has `in_tail`=1.
- R4: A granted flit with `in_head`=1 and `in_tail`=0 holds the port for its input. Until that input's tail flit is granted, no other input receives `in_ready`.
- R5: A flit granted in cycle t is written into the output buffer at the end of cycle t+1. When the buffer is empty it appears on `out_data`/`out_head`/`out_tail` with `out_valid`=1 in cycle t+2. Flits leave in the order they were granted.
- R6: A grant is issued only when the number of buffered flits plus the flit held in the pipeline register is below 3. The output buffer therefore never holds more than 3 flits.
- R7: While `out_valid`=1 and `out_ready`=0, the output flit and `out_valid` stay unchanged in the next cycle.
- R8: Every flit granted is delivered once. On the output each packet appears whole, from head to tail with consecutive flits, and no flit of another packet falls in between.
- R9: A granted flit with both `in_head` and `in_tail` set does not hold the port. It moves the priority pointer past its input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N_IN | Per input: a flit is offered |
| in_head | input | N_IN | Per input: offered flit starts a packet |
| in_tail | input | N_IN | Per input: offered flit ends a packet |
| in_data | input | N_IN*DATA_W | Per input flit payload; input i at bits [i*DATA_W +: DATA_W] |
| in_ready | output | N_IN | Per input grant; flit taken on this edge |
| out_valid | output | 1 | Output buffer holds a flit |
| out_head | output | 1 | Head marker of the output flit |
| out_tail | output | 1 | Tail marker of the output flit |
| out_data | output | DATA_W | Output flit payload |
| out_ready | input | 1 | Downstream accepts the output flit |

## Verification
The assertions assume well-formed input streams. Each input offers a head flit first, then the remaining flits of the same packet, ending with a tail. An offered flit stays valid and unchanged until its input is granted. The bench meets these assumptions by keeping a packet generator per input. Each generator holds its current flit until `in_ready` and starts a new packet of random length only after a tail has been taken. Downstream stalls are random, apart from one long stall that fills the buffer and one stretch with no stalls.

// File: rtl/eop_pkg.sv
package eop_pkg;

  typedef enum logic {
    PORT_OPEN = 1'b0,
    PORT_HELD = 1'b1
  } port_hold_e;

  // Rotating index: (base + off) reduced into 0..n-1 for off < n.
  function automatic int rot_idx(input int base, input int off, input int n);
    int s;
    s = base + off;
    if (s >= n) s = s - n;
    return s;
  endfunction

endpackage

// File: rtl/eop_rr_arbiter.sv
module eop_rr_arbiter #(
  parameter int N_IN = 4,
  localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] req,
  input  logic            win_tail,
  output logic            grant_vld,
  output logic [IW-1:0]   grant_idx
);
  import eop_pkg::*;

  logic [IW-1:0] ptr_q;
  logic [IW-1:0] ptr_d;
  logic          ptr_en;

  always_comb begin
    grant_vld = 1'b0;
    grant_idx = '0;
    for (int k = 0; k < N_IN; k++) begin
      if (!grant_vld && req[rot_idx(int'(ptr_q), k, N_IN)]) begin
        grant_vld = 1'b1;
        grant_idx = IW'(rot_idx(int'(ptr_q), k, N_IN));
      end
    end
  end

  // Pointer moves past the winner only when a packet ends.
  always_comb begin
    ptr_en = grant_vld && win_tail;
    ptr_d  = IW'(rot_idx(int'(grant_idx), 1, N_IN));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

endmodule

// File: rtl/eop_pkt_lock.sv
module eop_pkt_lock #(
  parameter int N_IN = 4,
  localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          grant_vld,
  input  logic [IW-1:0] grant_idx,
  input  logic          win_tail,
  output logic          held,
  output logic [IW-1:0] owner
);
  import eop_pkg::*;

  port_hold_e    st_q, st_d;
  logic [IW-1:0] own_q, own_d;
  logic          upd_en;

  always_comb begin
    upd_en = grant_vld;
    st_d   = win_tail ? PORT_OPEN : PORT_HELD;
    own_d  = grant_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PORT_OPEN;
      own_q <= '0;
    end else if (upd_en) begin
      st_q  <= st_d;
      own_q <= own_d;
    end
  end

  assign held  = (st_q == PORT_HELD);
  assign owner = own_q;

endmodule

// File: rtl/eop_out_fifo.sv
module eop_out_fifo #(
  parameter int W     = 18,
  parameter int DEPTH = 3,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic          nonempty,
  output logic [W-1:0]  head_data,
  output logic [CW-1:0] count
);
  logic [W-1:0]  slot_q [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_pop;

  always_comb begin
    do_pop = pop && (cnt_q != '0);
    wr_d   = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    rd_d   = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    cnt_d  = cnt_q + CW'(push) - CW'(do_pop);
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic slot_en;
    assign slot_en = push && (wr_q == PW'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[s] <= '0;
      end else if (slot_en) begin
        slot_q[s] <= push_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push)             wr_q  <= wr_d;
      if (do_pop)           rd_q  <= rd_d;
      if (push || do_pop)   cnt_q <= cnt_d;
    end
  end

  assign nonempty  = (cnt_q != '0);
  assign head_data = slot_q[rd_q];
  assign count     = cnt_q;

endmodule

// File: rtl/elastic_out_port.sv
module elastic_out_port #(
  parameter int N_IN      = 4,
  parameter int DATA_W    = 16,
  parameter int OUT_DEPTH = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_IN-1:0]          in_valid,
  input  logic [N_IN-1:0]          in_head,
  input  logic [N_IN-1:0]          in_tail,
  input  logic [N_IN*DATA_W-1:0]   in_data,
  output logic [N_IN-1:0]          in_ready,
  output logic                     out_valid,
  output logic                     out_head,
  output logic                     out_tail,
  output logic [DATA_W-1:0]        out_data,
  input  logic                     out_ready
);
  localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1;
  localparam int FW = DATA_W + 2;
  localparam int CW = $clog2(OUT_DEPTH + 1);

  logic [N_IN-1:0] req;
  logic            grant_vld;
  logic [IW-1:0]   grant_idx;
  logic            held;
  logic [IW-1:0]   owner;
  logic            room;
  logic [CW:0]     occ;
  logic [CW-1:0]   fifo_cnt;
  logic            win_head, win_tail;
  logic [FW-1:0]   win_flit;
  logic            pipe_v_q;
  logic [FW-1:0]   pipe_q;
  logic            fifo_ne;
  logic [FW-1:0]   fifo_head;

  // Room test counts the flit sitting in the pipeline register.
  always_comb begin
    occ  = {1'b0, fifo_cnt} + {{CW{1'b0}}, pipe_v_q};
    room = occ < (CW+1)'(OUT_DEPTH);
  end

  for (genvar g = 0; g < N_IN; g++) begin : g_req
    logic owns;
    assign owns     = (owner == IW'(g));
    assign req[g]   = room && in_valid[g] && (held ? owns : in_head[g]);
    assign in_ready[g] = grant_vld && (grant_idx == IW'(g));
  end

  always_comb begin
    win_head = in_head[grant_idx];
    win_tail = in_tail[grant_idx];
    win_flit = {win_head, win_tail, in_data[int'(grant_idx)*DATA_W +: DATA_W]};
  end

  eop_rr_arbiter #(.N_IN(N_IN)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .win_tail  (win_tail),
    .grant_vld (grant_vld),
    .grant_idx (grant_idx)
  );

  eop_pkt_lock #(.N_IN(N_IN)) u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .grant_vld (grant_vld),
    .grant_idx (grant_idx),
    .win_tail  (win_tail),
    .held      (held),
    .owner     (owner)
  );

  // Pipeline register between switch and output buffer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_v_q <= 1'b0;
    end else begin
      pipe_v_q <= grant_vld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
    end else if (grant_vld) begin
      pipe_q <= win_flit;
    end
  end

  eop_out_fifo #(.W(FW), .DEPTH(OUT_DEPTH)) u_obuf (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (pipe_v_q),
    .push_data (pipe_q),
    .pop       (out_ready),
    .nonempty  (fifo_ne),
    .head_data (fifo_head),
    .count     (fifo_cnt)
  );

  assign out_valid = fifo_ne;
  assign out_head  = fifo_head[FW-1];
  assign out_tail  = fifo_head[FW-2];
  assign out_data  = fifo_head[DATA_W-1:0];

endmodule

// File: rtl/eop_checker.sv
module eop_checker #(
  parameter int N_IN      = 4,
  parameter int DATA_W    = 16,
  parameter int OUT_DEPTH = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [N_IN-1:0]        in_valid,
  input logic [N_IN-1:0]        in_head,
  input logic [N_IN-1:0]        in_tail,
  input logic [N_IN-1:0]        in_ready,
  input logic                   out_valid,
  input logic                   out_head,
  input logic                   out_tail,
  input logic [DATA_W-1:0]      out_data,
  input logic                   out_ready
);
  localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1;
  localparam int OW = $clog2(OUT_DEPTH + 2) + 1;

  logic          chk_held;
  logic [IW-1:0] chk_owner;
  logic [OW-1:0] chk_out;
  logic          gnt_any;
  logic          gnt_head, gnt_tail;
  logic [IW-1:0] gnt_idx;

  always_comb begin
    gnt_any  = |in_ready;
    gnt_head = |(in_ready & in_head);
    gnt_tail = |(in_ready & in_tail);
    gnt_idx  = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (in_ready[i]) gnt_idx = IW'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_held  <= 1'b0;
      chk_owner <= '0;
      chk_out   <= '0;
    end else begin
      if (gnt_any) begin
        chk_held  <= !gnt_tail;
        chk_owner <= gnt_idx;
      end
      chk_out <= chk_out + OW'(gnt_any) - OW'(out_valid && out_ready);
    end
  end

  // R1
  r1_reset_idle_chk: assert property (@(posedge clk) !rst_n |-> !out_valid);

  // R2
  r2_single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready));

  // R2
  r2_grant_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready & ~in_valid) == '0);

  // R3
  r3_open_head_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_held |-> ((in_ready & ~in_head) == '0));

  // R4
  r4_no_interleave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_held |-> ((in_ready & ~(N_IN'(1) << chk_owner)) == '0));

  // R6
  r6_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_out <= OW'(OUT_DEPTH));

  // R7
  r7_hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                   && $stable(out_head) && $stable(out_tail)));

endmodule

bind elastic_out_port eop_checker #(
  .N_IN(N_IN), .DATA_W(DATA_W), .OUT_DEPTH(OUT_DEPTH)
) u_eop_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_head   (in_head),
  .in_tail   (in_tail),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_head  (out_head),
  .out_tail  (out_tail),
  .out_data  (out_data),
  .out_ready (out_ready)
);

// File: tb/test_elastic_out_port.sv
module test_elastic_out_port;
  localparam int N   = 4;
  localparam int DW  = 16;
  localparam int FW  = DW + 2;
  localparam int NPK = 40;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [N-1:0]    in_valid, in_head, in_tail, in_ready;
  logic [N*DW-1:0] in_data;
  logic            out_valid, out_head, out_tail, out_ready;
  logic [DW-1:0]   out_data;

  elastic_out_port #(.N_IN(N), .DATA_W(DW), .OUT_DEPTH(3)) i_elastic_out_port (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_head(in_head), .in_tail(in_tail), .in_data(in_data),
    .in_ready(in_ready),
    .out_valid(out_valid), .out_head(out_head), .out_tail(out_tail),
    .out_data(out_data), .out_ready(out_ready)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // source state
  int src_len [N];
  int src_idx [N];
  int src_seq [N];
  // reference model state
  bit m_held;
  int m_owner, m_ptr;
  bit m_pv;
  logic [FW-1:0] m_pipe;
  logic [FW-1:0] m_q[$];
  // output integrity state
  int  exp_seq [N];
  bit  o_in_pkt;
  int  o_src, o_idx;
  int  sent_flits, got_flits;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  function automatic logic [FW-1:0] mk_flit(input int s);
    return {src_idx[s] == 0, src_idx[s] == src_len[s] - 1,
            4'(s), 8'(src_seq[s]), 4'(src_idx[s])};
  endfunction

  // Expected grant from the requirements (R3, R4, R6, R9)
  function automatic int exp_grant();
    if (m_q.size() + int'(m_pv) >= 3) return -1;
    for (int k = 0; k < N; k++) begin
      int c;
      c = (m_ptr + k) % N;
      if (in_valid[c] && (m_held ? (c == m_owner) : in_head[c])) return c;
    end
    return -1;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b1; in_valid = '0; in_head = '0; in_tail = '0; in_data = '0;
    out_ready = 1'b0;
    #1 rst_n = 1'b0;
    for (int s = 0; s < N; s++) begin
      src_len[s] = 0; src_idx[s] = 0; src_seq[s] = 0; exp_seq[s] = 0;
    end
    m_held = 0; m_owner = 0; m_ptr = 0; m_pv = 0;
    o_in_pkt = 0; o_src = 0; o_idx = 0; sent_flits = 0; got_flits = 0;
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R1", "out_valid in reset", 32'(out_valid), 0);
    @(negedge clk) rst_n = 1'b1;
    #1;
    check(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 0);
    check(in_ready == '0, "R1", "in_ready idle", 32'(in_ready), 0);

    for (int cyc = 0; cyc < 20000; cyc++) begin
      int eg;
      bit all_done;
      logic [FW-1:0] gflit;
      @(negedge clk);
      // drive sources
      for (int s = 0; s < N; s++) begin
        if (src_len[s] == 0 && src_seq[s] < NPK && ($urandom % 4) != 0) begin
          src_len[s] = 1 + int'($urandom % 4);
          src_idx[s] = 0;
        end
        if (src_len[s] != 0) begin
          logic [FW-1:0] f;
          f = mk_flit(s);
          in_valid[s] = 1'b1;
          in_head[s]  = f[FW-1];
          in_tail[s]  = f[FW-2];
          in_data[s*DW +: DW] = f[DW-1:0];
        end else begin
          in_valid[s] = 1'b0; in_head[s] = 1'b0; in_tail[s] = 1'b0;
          in_data[s*DW +: DW] = '0;
        end
      end
      if (cyc >= 5 && cyc < 30)        out_ready = 1'b0;  // long stall fills buffer (R6)
      else if (cyc >= 100 && cyc < 200) out_ready = 1'b1; // full-rate stretch (R5)
      else                              out_ready = ($urandom % 10) < 7;
      #1;
      // R2/R3/R4/R6/R9 grant check
      eg = exp_grant();
      check(in_ready == ((eg < 0) ? 4'b0 : 4'(1 << eg)), "R3/R4/R6",
            "in_ready", 32'(in_ready), (eg < 0) ? 0 : 32'(1 << eg));
      // R5 and R7: output matches model buffer head
      check(out_valid == (m_q.size() > 0), "R5", "out_valid",
            32'(out_valid), 32'(m_q.size() > 0));
      if (m_q.size() > 0 && out_valid)
        check({out_head, out_tail, out_data} == m_q[0], "R5/R7", "out flit",
              32'({out_head, out_tail, out_data}), 32'(m_q[0]));
      // R8: packet integrity at output
      if (out_valid && out_ready) begin
        int fs, fq, fi;
        fs = int'(out_data[15:12]); fq = int'(out_data[11:4]); fi = int'(out_data[3:0]);
        got_flits++;
        if (out_head) begin
          check(!o_in_pkt, "R8", "head inside packet", 32'(fs), 32'(o_src));
          check(fq == exp_seq[fs % N] && fi == 0, "R8", "packet sequence",
                32'(fq), 32'(exp_seq[fs % N]));
          o_in_pkt = 1; o_src = fs; o_idx = 0;
        end else begin
          check(o_in_pkt && fs == o_src && fi == o_idx + 1, "R8", "body flit",
                32'(out_data), 32'({4'(o_src), 8'(exp_seq[o_src % N]), 4'(o_idx + 1)}));
          o_idx = fi;
        end
        if (out_tail) begin
          o_in_pkt = 0;
          exp_seq[fs % N] = exp_seq[fs % N] + 1;
        end
      end
      // advance model to the next edge
      if (out_ready && m_q.size() > 0) void'(m_q.pop_front());
      if (m_pv) m_q.push_back(m_pipe);
      m_pv = (eg >= 0);
      if (eg >= 0) begin
        gflit = {in_head[eg], in_tail[eg], in_data[eg*DW +: DW]};
        m_pipe = gflit;
        if (in_tail[eg]) begin
          m_held = 0;                       // R9: single-flit packets never hold
          m_ptr = (eg + 1) % N;
        end else begin
          m_held = 1; m_owner = eg;
        end
      end
      // advance sources on actual grant
      for (int s = 0; s < N; s++) begin
        if (in_ready[s] && src_len[s] != 0) begin
          sent_flits++;
          if (src_idx[s] == src_len[s] - 1) begin
            src_len[s] = 0; src_seq[s]++;
          end else begin
            src_idx[s]++;
          end
        end
      end
      all_done = 1;
      for (int s = 0; s < N; s++)
        if (src_seq[s] < NPK || src_len[s] != 0) all_done = 0;
      if (all_done && m_q.size() == 0 && !m_pv) break;
    end
    // R8: nothing dropped or duplicated
    check(got_flits == sent_flits, "R8", "delivered flits",
          32'(got_flits), 32'(sent_flits));
    for (int s = 0; s < N; s++)
      check(exp_seq[s] == NPK, "R8", "packets per input", 32'(exp_seq[s]), NPK);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R8 watchdog actual=%0d expected=%0d", got_flits, sent_flits);
      summary();
      $finish;
    end
  end

endmodule